// File: doc/BRIEF.md
# Link Rate and Lane Fallback Stepper

This block picks the next, slower configuration for a serial display link after a training attempt has failed. The caller gives it the rate code and lane count that just failed, along with the highest rate and the widest lane count the sink supports. One clock later the block returns the configuration to try next and a flag that says whether a usable step down exists.

The order of the steps is not a plain halving. The block moves among three per-lane rate codes using rules that depend on the lane count. At the top rate with a single lane, it drops the rate and opens the link back up to the sink's full width. At the bottom rate it can raise the rate while it halves the width.

When no usable step exists, the block presents the configuration that came with the request, which it keeps in its own registers. The caller can restore that configuration directly. Checking the video bandwidth and writing to the sink are left to other logic.

Top module: `link_fallback_step`

## Requirements
- R1: While reset is held and after it is released, rspValid, failFlag, nextRate and nextLanes are all 0 until the first request.
- R2: rspValid is 1 in exactly the cycle after a cycle with reqValid at 1, and 0 after a cycle with reqValid at 0.
- R3: With curRate = 0x0A (2.7 Gb/s) and a nonzero lane count, the response is rate 0x06 (1.62 Gb/s) with the lane count unchanged and failFlag 0.
- R4: With curRate = 0x14 (5.4 Gb/s) and curLanes above 1, the response keeps rate 0x14 with curLanes shifted right by one.
- R5: With curRate = 0x14 and curLanes = 1, the response is rate 0x0A with the lane count set to maxLanes.
- R6: With curRate = 0x06 and maxRate numerically above 0x06, the response is rate 0x0A with curLanes shifted right by one.
- R7: With curRate = 0x06 and maxRate at most 0x06, the response keeps rate 0x06 with curLanes shifted right by one.
- R8: Any curRate other than 0x06, 0x0A or 0x14 gives failFlag 1, and nextRate/nextLanes equal the request's own curRate/curLanes.
- R9: When the computed lane count would be 0, failFlag is 1 and nextRate/nextLanes equal the request's own curRate/curLanes.
- R10: Without a request, nextRate, nextLanes and failFlag hold their values, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| curRate | input | 8 | Rate code that failed training |
| curLanes | input | 3 | Lane count that failed training (1, 2 or 4) |
| maxRate | input | 8 | Highest rate code of the sink |
| maxLanes | input | 3 | Widest lane count of the sink |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| nextRate | output | 8 | Rate code to try next, or the saved rate on failure |
| nextLanes | output | 3 | Lane count to try next, or the saved count on failure |
| failFlag | output | 1 | 1 when no usable step down exists |

## Verification
The hardest case to reach is a failure that the rate rules themselves produce. In this case the block computes a legal new rate, and the request fails only because the lane count reaches zero. Examples are the bottom rate at one lane with a faster sink, and the top rate at one lane with a sink that reports zero lanes. The stimulus table drives these cases on purpose. It checks that the saved configuration appears on the outputs and not the partly computed one. Separate directed steps change the inputs without a request, to show that the outputs hold.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  localparam int RATE_W = 8;
  localparam int LANE_W = 3;
  localparam logic [RATE_W-1:0] RATE_LO  = 8'h06;
  localparam logic [RATE_W-1:0] RATE_MID = 8'h0A;
  localparam logic [RATE_W-1:0] RATE_HI  = 8'h14;

  typedef struct packed {
    logic capture;
  } lfbStrobes_t;
endpackage

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output lfbStrobes_t strobes,
  output logic        rspValid
);
  always_comb strobes.capture = reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/lfb_datapath.sv
module lfb_datapath
  import lfb_pkg::*;
#(
  parameter int RW = RATE_W,
  parameter int LW = LANE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  lfbStrobes_t   strobes,
  input  logic [RW-1:0] curRate,
  input  logic [LW-1:0] curLanes,
  input  logic [RW-1:0] maxRate,
  input  logic [LW-1:0] maxLanes,
  output logic [RW-1:0] nextRate,
  output logic [LW-1:0] nextLanes,
  output logic          failFlag
);
  logic [RW-1:0] candRate;
  logic [LW-1:0] candLanes;
  logic          codeBad;
  logic          candFail;
  logic [RW-1:0] saveRate, candRateQ;
  logic [LW-1:0] saveLanes, candLanesQ;
  logic          failQ;

  always_comb begin
    candRate  = curRate;
    candLanes = curLanes;
    codeBad   = 1'b0;
    case (curRate)
      RATE_LO: begin
        candLanes = curLanes >> 1;
        candRate  = (maxRate > RATE_LO) ? RATE_MID : RATE_LO;
      end
      RATE_MID: begin
        candRate = RATE_LO;
      end
      RATE_HI: begin
        if (curLanes == LW'(1)) begin
          candRate  = RATE_MID;
          candLanes = maxLanes;
        end else begin
          candLanes = curLanes >> 1;
        end
      end
      default: codeBad = 1'b1;
    endcase
    candFail = codeBad || (candLanes == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      saveRate   <= '0;
      saveLanes  <= '0;
      candRateQ  <= '0;
      candLanesQ <= '0;
      failQ      <= 1'b0;
    end else if (strobes.capture) begin
      saveRate   <= curRate;
      saveLanes  <= curLanes;
      candRateQ  <= candRate;
      candLanesQ <= candLanes;
      failQ      <= candFail;
    end
  end

  always_comb begin
    failFlag  = failQ;
    nextRate  = failQ ? saveRate  : candRateQ;
    nextLanes = failQ ? saveLanes : candLanesQ;
  end
endmodule

// File: rtl/link_fallback_step.sv
module link_fallback_step
  import lfb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [RATE_W-1:0] curRate,
  input  logic [LANE_W-1:0] curLanes,
  input  logic [RATE_W-1:0] maxRate,
  input  logic [LANE_W-1:0] maxLanes,
  output logic              rspValid,
  output logic [RATE_W-1:0] nextRate,
  output logic [LANE_W-1:0] nextLanes,
  output logic              failFlag
);
  lfbStrobes_t strobes;

  lfb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .strobes(strobes), .rspValid(rspValid)
  );

  lfb_datapath #(.RW(RATE_W), .LW(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .curRate(curRate), .curLanes(curLanes),
    .maxRate(maxRate), .maxLanes(maxLanes),
    .nextRate(nextRate), .nextLanes(nextLanes), .failFlag(failFlag)
  );
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker
  import lfb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [RATE_W-1:0] curRate,
  input logic [LANE_W-1:0] curLanes,
  input logic [RATE_W-1:0] maxRate,
  input logic [LANE_W-1:0] maxLanes,
  input logic              rspValid,
  input logic [RATE_W-1:0] nextRate,
  input logic [LANE_W-1:0] nextLanes,
  input logic              failFlag
);
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  a_r3_mid_to_lo: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curRate == RATE_MID && curLanes != '0) |=>
      (nextRate == RATE_LO && nextLanes == $past(curLanes) && !failFlag));
  a_r5_hi_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curRate == RATE_HI && curLanes == 3'd1 && maxLanes != '0) |=>
      (nextRate == RATE_MID && nextLanes == $past(maxLanes) && !failFlag));
  a_r8_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curRate != RATE_LO && curRate != RATE_MID && curRate != RATE_HI) |=>
      (failFlag && nextRate == $past(curRate) && nextLanes == $past(curLanes)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(nextRate) && $stable(nextLanes) && $stable(failFlag)));
endmodule

bind link_fallback_step lfb_checker chk_i (.*);

// File: tb/link_fallback_step_tb_top.sv
module link_fallback_step_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] curRate = '0, maxRate = '0;
  logic [2:0] curLanes = '0, maxLanes = '0;
  logic       rspValid, failFlag;
  logic [7:0] nextRate;
  logic [2:0] nextLanes;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_fallback_step dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .curRate(curRate), .curLanes(curLanes),
    .maxRate(maxRate), .maxLanes(maxLanes),
    .rspValid(rspValid), .nextRate(nextRate),
    .nextLanes(nextLanes), .failFlag(failFlag)
  );

  // {curRate, curLanes, maxRate, maxLanes, expRate, expLanes, expFail}
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {8'h0A, 3'd4, 8'h14, 3'd4, 8'h06, 3'd4, 1'b0},  // R3
    {8'h0A, 3'd1, 8'h0A, 3'd2, 8'h06, 3'd1, 1'b0},  // R3
    {8'h14, 3'd4, 8'h14, 3'd4, 8'h14, 3'd2, 1'b0},  // R4
    {8'h14, 3'd2, 8'h14, 3'd4, 8'h14, 3'd1, 1'b0},  // R4
    {8'h14, 3'd1, 8'h14, 3'd4, 8'h0A, 3'd4, 1'b0},  // R5
    {8'h14, 3'd1, 8'h14, 3'd2, 8'h0A, 3'd2, 1'b0},  // R5
    {8'h06, 3'd4, 8'h14, 3'd4, 8'h0A, 3'd2, 1'b0},  // R6
    {8'h06, 3'd2, 8'h0A, 3'd4, 8'h0A, 3'd1, 1'b0},  // R6
    {8'h06, 3'd4, 8'h06, 3'd4, 8'h06, 3'd2, 1'b0},  // R7
    {8'h06, 3'd2, 8'h06, 3'd2, 8'h06, 3'd1, 1'b0},  // R7
    {8'h06, 3'd1, 8'h14, 3'd4, 8'h06, 3'd1, 1'b1},  // R9
    {8'h06, 3'd1, 8'h06, 3'd1, 8'h06, 3'd1, 1'b1},  // R9
    {8'h14, 3'd1, 8'h14, 3'd0, 8'h14, 3'd1, 1'b1},  // R9
    {8'h0B, 3'd2, 8'h14, 3'd4, 8'h0B, 3'd2, 1'b1},  // R8
    {8'h00, 3'd4, 8'h14, 3'd4, 8'h00, 3'd4, 1'b1}   // R8
  };
  localparam string TAG [NV] = '{"R3","R3","R4","R4","R5","R5","R6","R6",
                                 "R7","R7","R9","R9","R9","R8","R8"};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic request(input logic [7:0] r, input logic [2:0] l,
                         input logic [7:0] mr, input logic [2:0] ml);
    @(negedge clk);
    curRate = r; curLanes = l; maxRate = mr; maxLanes = ml; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", {4'd0, rspValid, failFlag, nextRate, nextLanes, 1'b0}, 16'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {4'd0, rspValid, failFlag, nextRate, nextLanes, 1'b0}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      request(VEC[i][33:26], VEC[i][25:23], VEC[i][22:15], VEC[i][14:12]);
      check("R2", {15'd0, rspValid}, 16'd1);
      check(TAG[i], {4'd0, failFlag, nextRate, nextLanes},
            {4'd0, VEC[i][0], VEC[i][11:4], VEC[i][3:1]});
    end

    // R2: pulse lasts one cycle
    @(negedge clk);
    check("R2", {15'd0, rspValid}, 16'd0);

    // R10: inputs change without a request; outputs hold the last failure
    curRate = 8'h0A; curLanes = 3'd4; maxRate = 8'h14; maxLanes = 3'd4;
    repeat (3) @(negedge clk);
    check("R10", {4'd0, failFlag, nextRate, nextLanes}, {4'd0, 1'b1, 8'h00, 3'd4});
    check("R2", {15'd0, rspValid}, 16'd0);

    // R10: hold after a success, then back-to-back requests
    request(8'h14, 3'd4, 8'h14, 3'd4);
    curRate = 8'h99; curLanes = 3'd0;
    repeat (2) @(negedge clk);
    check("R10", {4'd0, failFlag, nextRate, nextLanes}, {4'd0, 1'b0, 8'h14, 3'd2});

    // R2: back-to-back requests keep valid high each cycle
    @(negedge clk);
    curRate = 8'h0A; curLanes = 3'd2; reqValid = 1'b1;
    @(negedge clk);
    check("R2", {15'd0, rspValid}, 16'd1);
    check("R3", {4'd0, failFlag, nextRate, nextLanes}, {4'd0, 1'b0, 8'h06, 3'd2});
    curRate = 8'h06; curLanes = 3'd2; maxRate = 8'h06;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2", {15'd0, rspValid}, 16'd1);
    check("R7", {4'd0, failFlag, nextRate, nextLanes}, {4'd0, 1'b0, 8'h06, 3'd1});

    // R1: reset again clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R1", {4'd0, rspValid, failFlag, nextRate, nextLanes, 1'b0}, 16'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule